// File: doc/BRIEF.md
# Sampling ADC conversion controller

This block runs an external edge-triggered 12-bit sampling converter from a system clock. On a sample-rate tick it raises a start-convert pulse whose width is a fixed number of clocks. It then follows the converter's end-of-conversion (EOC) line through a synchronizer. Once EOC has been high and has fallen, it enables the converter's three-state outputs (active-low) for a settle window. It latches the parallel word on the last clock of that window. The converter has no pipeline delay, so the latched word always belongs to the conversion this block just started.

Each latched word is offered on a valid/ready stream. The word can optionally be turned from offset binary into two's complement. The stream holds one sample. `m_valid` never waits on `m_ready`. Once `m_valid` is high, the sample and `m_valid` stay unchanged until a cycle where `m_ready` is high, and that cycle completes the transfer. If the held sample has not been taken by the time a new word is latched, the new word is discarded and an overrun count goes up.

A tick is refused while a conversion is in progress or while the synchronized EOC is high, because retriggering a busy converter corrupts the result. If EOC does not fall within a timeout, a sticky error flag is set and the controller goes idle.

Top module: `adc_conv_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no tick: `adc_start` is 0, `adc_oe_n` is 1, `m_valid` is 0, `err_timeout` is 0 and `overrun_cnt` is 0.
- R2: A `rate_tick` seen at a clock edge while idle, with synchronized EOC low, makes `adc_start` high from that edge for exactly PULSE_CYC clocks (default 20).
- R3: A `rate_tick` has no effect in two cases: while a conversion is in progress (pulse, waiting for EOC, settle), or while EOC delayed by SYNC_STAGES clocks (default 2) is high. In both cases no extra `adc_start` pulse appears.
- R4: After the synchronized EOC has been seen high and then low, `adc_oe_n` is low for exactly SETTLE_CYC clocks (default 6). `adc_data` is sampled at the edge that ends this window.
- R5: `m_valid` rises in the clock right after that sampling edge. It carries the word of the conversion just started, not the previous one.
- R6: With `cfg_twos` = 0 the word is passed unchanged (offset binary: 0x000 = negative full scale, 0x800 = zero). With `cfg_twos` = 1 bit 11 is inverted: 0x800 gives 0x000, 0x000 gives 0x800, 0xFFF gives 0x7FF. `cfg_twos` is sampled at the latch edge.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold. After a cycle with `m_ready` high and no new latch, `m_valid` is 0.
- R8: At a latch edge where `m_valid` is high and `m_ready` is low, the new word is dropped and `m_data` is unchanged. In that case `overrun_cnt` increases by 1, saturating at 2^OVR_W-1.
- R9: If EOC has not fallen within TIMEOUT_CYC clocks (default 64) after the pulse ends, `err_timeout` goes high. The controller then returns to idle without lowering `adc_oe_n` and without producing a sample.
- R10: `err_timeout` stays high until reset. Later conversions still work normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_tick | input | 1 | Sample-rate request, one clock wide |
| cfg_twos | input | 1 | 1: output two's complement, 0: offset binary |
| adc_eoc | input | 1 | Converter end-of-conversion, asynchronous |
| adc_data | input | 12 | Converter parallel output word |
| adc_start | output | 1 | Start-convert pulse to the converter |
| adc_oe_n | output | 1 | Converter output enable, active low |
| m_valid | output | 1 | Sample stream valid |
| m_ready | input | 1 | Sample stream ready |
| m_data | output | 12 | Sample stream word |
| err_timeout | output | 1 | Sticky EOC timeout flag |
| overrun_cnt | output | 8 | Saturating count of dropped samples |

## Verification
A sequencer stuck in the wrong phase or off by one count shows at the pins within a single conversion. It appears as a start pulse of the wrong width, as an output-enable window that is shifted or of the wrong length, or as a missing or extra start pulse after a refused tick. A fault in the output slot appears as `m_valid` or `m_data` changing while back-pressure is applied, or as an overrun count that disagrees with the drops. A slip in the EOC synchronizer moves the enable window by whole clocks. Since every output is compared with the reference model on each clock, a divergence is reported in the cycle it first reaches a port.

// File: rtl/adc_ctrl_pkg.sv
`timescale 1ns/1ps
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_SETTLE
  } seq_state_t;
endpackage

// File: rtl/adc_sync.sv
`timescale 1ns/1ps
module adc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (STAGES <= 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= 1'b0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq
  import adc_ctrl_pkg::*;
#(
  parameter int PULSE_CYC   = 20,
  parameter int SETTLE_CYC  = 6,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_tick,
  input  logic eoc_s,
  output logic start_o,
  output logic oe_n_o,
  output logic latch_o,
  output logic err_o
);
  localparam int MAX_A = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int MAX_C = (MAX_A > TIMEOUT_CYC) ? MAX_A : TIMEOUT_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TIMEOUT_CYC - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             seen_hi;
  logic             eoc_done;

  assign eoc_done = seen_hi & ~eoc_s;
  assign latch_o  = (state == ST_SETTLE) && (cnt == SETTLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      seen_hi <= 1'b0;
      start_o <= 1'b0;
      oe_n_o  <= 1'b1;
      err_o   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rate_tick && !eoc_s) begin
            state   <= ST_PULSE;
            cnt     <= '0;
            seen_hi <= 1'b0;
            start_o <= 1'b1;
          end
        end
        ST_PULSE: begin
          if (eoc_s) seen_hi <= 1'b1;
          if (cnt == PULSE_LAST) begin
            state   <= ST_WAIT;
            cnt     <= '0;
            start_o <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (eoc_done) begin
            state  <= ST_SETTLE;
            cnt    <= '0;
            oe_n_o <= 1'b0;
          end else begin
            if (eoc_s) seen_hi <= 1'b1;
            if (cnt == TMO_LAST) begin
              err_o <= 1'b1;
              state <= ST_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            oe_n_o <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_fmt.sv
`timescale 1ns/1ps
module adc_fmt #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] raw,
  input  logic          twos,
  output logic [DW-1:0] word
);
  assign word = {raw[DW-1] ^ twos, raw[DW-2:0]};
endmodule

// File: rtl/adc_slot.sv
`timescale 1ns/1ps
module adc_slot #(
  parameter int DW    = 12,
  parameter int OVR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DW-1:0]    din,
  input  logic             m_ready,
  output logic             m_valid,
  output logic [DW-1:0]    m_data,
  output logic [OVR_W-1:0] ovr
);
  logic blocked;
  assign blocked = m_valid & ~m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      ovr     <= '0;
    end else if (load) begin
      if (blocked) begin
        if (ovr != {OVR_W{1'b1}}) ovr <= ovr + 1'b1;
      end else begin
        m_data  <= din;
        m_valid <= 1'b1;
      end
    end else if (m_valid && m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_ctrl.sv
`timescale 1ns/1ps
module adc_conv_ctrl #(
  parameter int DW          = 12,
  parameter int PULSE_CYC   = 20,
  parameter int SETTLE_CYC  = 6,
  parameter int TIMEOUT_CYC = 64,
  parameter int SYNC_STAGES = 2,
  parameter int OVR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_tick,
  input  logic             cfg_twos,
  input  logic             adc_eoc,
  input  logic [DW-1:0]    adc_data,
  output logic             adc_start,
  output logic             adc_oe_n,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [DW-1:0]    m_data,
  output logic             err_timeout,
  output logic [OVR_W-1:0] overrun_cnt
);
  logic          eoc_s;
  logic          latch;
  logic [DW-1:0] word;

  adc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(adc_eoc), .q(eoc_s)
  );

  adc_seq #(
    .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .eoc_s(eoc_s),
    .start_o(adc_start), .oe_n_o(adc_oe_n), .latch_o(latch), .err_o(err_timeout)
  );

  adc_fmt #(.DW(DW)) u_fmt (
    .raw(adc_data), .twos(cfg_twos), .word(word)
  );

  adc_slot #(.DW(DW), .OVR_W(OVR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(latch), .din(word), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .ovr(overrun_cnt)
  );
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
`timescale 1ns/1ps
module adc_conv_ctrl_chk #(
  parameter int DW    = 12,
  parameter int OVR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adc_start,
  input logic             adc_oe_n,
  input logic             m_valid,
  input logic             m_ready,
  input logic [DW-1:0]    m_data,
  input logic             err_timeout,
  input logic [OVR_W-1:0] overrun_cnt,
  input logic             eoc_s
);
  assert_start_needs_eoc_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_start) |-> !$past(eoc_s));

  assert_oe_outside_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(adc_start && !adc_oe_n));

  assert_valid_after_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(!adc_oe_n));

  assert_hold_under_backpressure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_overrun_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((overrun_cnt == $past(overrun_cnt)) ||
              (overrun_cnt == $past(overrun_cnt) + 1'b1)));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.DW(DW), .OVR_W(OVR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_oe_n(adc_oe_n),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .err_timeout(err_timeout), .overrun_cnt(overrun_cnt), .eoc_s(eoc_s)
);

// File: tb/sim_adc_conv_ctrl.sv
`timescale 1ns/1ps
module sim_adc_conv_ctrl;
  localparam int PULSE  = 20;
  localparam int SETTLE = 6;
  localparam int TMO    = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_tick = 1'b0;
  logic        cfg_twos = 1'b0;
  logic        eoc_beh = 1'b0;
  logic        force_eoc = 1'b0;
  logic        adc_eoc;
  logic [11:0] adc_data = 12'h000;
  logic        m_ready = 1'b0;
  logic        adc_start, adc_oe_n, m_valid, err_timeout;
  logic [11:0] m_data;
  logic [7:0]  overrun_cnt;

  logic [11:0] conv_val = 12'h000;
  logic        stuck = 1'b0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  assign adc_eoc = eoc_beh | force_eoc;

  always #2.5 clk = ~clk;

  adc_conv_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .cfg_twos(cfg_twos),
    .adc_eoc(adc_eoc), .adc_data(adc_data), .adc_start(adc_start),
    .adc_oe_n(adc_oe_n), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .err_timeout(err_timeout), .overrun_cnt(overrun_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural converter: offsets keep every pin change away from clock edges.
  always @(posedge adc_start) begin
    #12  eoc_beh = 1'b1;
    #119 adc_data = 12'hEEE;
    #22  if (stuck) wait (!stuck);
    eoc_beh = 1'b0;
    #21  adc_data = conv_val;
  end

  // Cycle reference model: phases with count-down timers.
  int ph = 0, left = 0, seen = 0, s0 = 0, s1 = 0, es = 0, fire = 0;
  int e_start = 0, e_oen = 1, e_err = 0, e_valid = 0, e_data = 0, e_ovr = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; seen = 0; s0 = 0; s1 = 0;
      e_start = 0; e_oen = 1; e_err = 0; e_valid = 0; e_data = 0; e_ovr = 0;
    end else begin
      es = s1; s1 = s0; s0 = int'(adc_eoc);
      fire = 0;
      case (ph)
        0: if (rate_tick && es == 0) begin ph = 1; left = PULSE; e_start = 1; seen = 0; end
        1: begin
          if (es != 0) seen = 1;
          left--;
          if (left == 0) begin ph = 2; left = TMO; e_start = 0; end
        end
        2: begin
          if (seen != 0 && es == 0) begin ph = 3; left = SETTLE; e_oen = 0; end
          else begin
            if (es != 0) seen = 1;
            left--;
            if (left == 0) begin e_err = 1; ph = 0; end
          end
        end
        default: begin
          left--;
          if (left == 0) begin fire = 1; ph = 0; e_oen = 1; end
        end
      endcase
      if (fire != 0) begin
        if (e_valid != 0 && !m_ready) begin
          if (e_ovr < 255) e_ovr++;
        end else begin
          e_data = cfg_twos ? int'(adc_data ^ 12'h800) : int'(adc_data);
          e_valid = 1;
        end
      end else if (e_valid != 0 && m_ready) begin
        e_valid = 0;
      end
    end
  end

  // Per-cycle comparison and pulse-width monitor.
  int hi_len = 0;
  int starts = 0;
  logic prev_start = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 adc_start", int'(adc_start), e_start);
      chk("R4 adc_oe_n", int'(adc_oe_n), e_oen);
      chk("R5 m_valid", int'(m_valid), e_valid);
      if (e_valid != 0) chk("R6 m_data", int'(m_data), e_data);
      chk("R9 err_timeout", int'(err_timeout), e_err);
      chk("R8 overrun_cnt", int'(overrun_cnt), e_ovr);
      if (adc_start && !prev_start) starts++;
      if (adc_start) hi_len++;
      else if (hi_len != 0) begin
        chk("R2 start width", hi_len, PULSE);
        hi_len = 0;
      end
      prev_start = adc_start;
    end
  end

  task automatic tick();
    @(negedge clk) rate_tick = 1'b1;
    @(negedge clk) rate_tick = 1'b0;
  endtask

  task automatic conv(input logic [11:0] v);
    conv_val = v;
    tick();
    repeat (50) @(negedge clk);
  endtask

  task automatic take();
    @(negedge clk) m_ready = 1'b1;
    @(negedge clk) m_ready = 1'b0;
  endtask

  task automatic conv_check(input logic [11:0] v, input logic tw, input logic [11:0] exp, input string tag);
    cfg_twos = tw;
    conv(v);
    chk({tag, " valid"}, int'(m_valid), 1);
    chk({tag, " data"}, int'(m_data), int'(exp));
    take();
    chk("R7 valid cleared after handshake", int'(m_valid), 0);
  endtask

  initial begin
    int s_before;
    repeat (3) @(negedge clk);
    chk("R1 start in reset", int'(adc_start), 0);
    chk("R1 oe_n in reset", int'(adc_oe_n), 1);
    chk("R1 valid in reset", int'(m_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 err after reset", int'(err_timeout), 0);
    chk("R1 overrun after reset", int'(overrun_cnt), 0);
    chk("R1 start idle", int'(adc_start), 0);

    conv_check(12'h123, 1'b0, 12'h123, "R5 offset word");
    conv_check(12'h800, 1'b1, 12'h000, "R6 zero to twos");
    conv_check(12'h000, 1'b1, 12'h800, "R6 neg full scale");
    conv_check(12'hFFF, 1'b1, 12'h7FF, "R6 pos full scale");
    conv_check(12'hFFF, 1'b0, 12'hFFF, "R6 offset pass");
    cfg_twos = 1'b0;
    conv(12'h3C3);
    take();
    conv_check(12'h5A5, 1'b0, 12'h5A5, "R5 no pipeline");

    // R3: ticks during a conversion are refused
    s_before = starts;
    conv_val = 12'h0AA;
    tick();
    repeat (5) @(negedge clk);
    tick();
    repeat (25) @(negedge clk);
    tick();
    repeat (40) @(negedge clk);
    chk("R3 busy ticks refused", starts - s_before, 1);
    chk("R3 sample of first tick", int'(m_data), 12'h0AA);
    take();

    // R3: tick while EOC held high in idle
    s_before = starts;
    force_eoc = 1'b1;
    repeat (4) @(negedge clk);
    tick();
    repeat (10) @(negedge clk);
    chk("R3 refused while eoc high", starts - s_before, 0);
    force_eoc = 1'b0;
    repeat (4) @(negedge clk);

    // R8: overrun under back-pressure
    conv(12'h111);
    chk("R8 first held", int'(m_data), 12'h111);
    conv(12'h222);
    chk("R8 dropped keeps data", int'(m_data), 12'h111);
    chk("R8 count one", int'(overrun_cnt), 1);
    conv(12'h333);
    chk("R8 count two", int'(overrun_cnt), 2);
    chk("R7 still held", int'(m_valid), 1);
    take();

    // R9: EOC never falls
    stuck = 1'b1;
    conv(12'h444);
    repeat (60) @(negedge clk);
    chk("R9 err set", int'(err_timeout), 1);
    chk("R9 no sample", int'(m_valid), 0);
    stuck = 1'b0;
    repeat (20) @(negedge clk);

    // R10: sticky, later conversions fine
    conv_check(12'h0F0, 1'b0, 12'h0F0, "R10 after error");
    chk("R10 err sticky", int'(err_timeout), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired R1 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule